// File: doc/BRIEF.md
# Peripheral Soft-Reset Handshake Sequencer

This block is a small bus master that takes a peripheral through a soft-reset handshake. The peripheral exposes one 32-bit control word at three addresses: a base address that is read, a "set" alias where every 1 written sets that bit, and a "clear" alias where every 1 written clears that bit. One control bit asks the peripheral to reset itself, and another gates its clock. The peripheral answers a reset request by raising its clock-gate bit.

A single-cycle start request launches a fixed program of writes and polls. The writes go to the aliases. The polls read the base address until a chosen bit reaches its target level, with one microsecond between polls and a bounded number of polls per wait. The block ends with a one-cycle done pulse, or with a one-cycle error pulse if any wait runs out of polls. Accesses go one at a time over a request/ready port.

Top module: `periph_reset_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bus_req_o are all low, and bus_req_o stays low whenever busy_o is low.
- R2: A start_i pulse while busy_o is low is taken on that clock edge: busy_o and bus_req_o are high from the next cycle.
- R3: A successful run issues exactly this access order (set alias = base + 4, clear alias = base + 8, reads at base): write clear reset-bit; poll until reset-bit is 0; write clear gate-bit; write set reset-bit; poll until gate-bit is 1; write clear reset-bit; poll until reset-bit is 0; write clear gate-bit; poll until gate-bit is 0.
- R4: A poll for 1 passes only when every bit of its mask reads 1. A poll for 0 passes only when every mask bit reads 0. All other read bits are ignored.
- R5: After a failing poll is accepted, the next poll request rises exactly CLK_HZ/1,000,000 clock cycles later. At 50 MHz this is 50 cycles.
- R6: A wait that sees POLL_LIMIT failing reads ends the run. err_o pulses for one cycle in the cycle after the last read is accepted, no further access is issued, and done_o stays low.
- R7: After the final poll passes, done_o pulses for exactly one cycle and busy_o falls in that same cycle. done_o and err_o are never high together.
- R8: start_i is ignored while busy_o is high. The access order and the outcome of the run in progress are unchanged.
- R9: While bus_req_o is high and bus_ready_i is low, bus_addr_o, bus_wdata_o and bus_we_o hold their values into the next cycle, and bus_req_o stays high.
- R10: The poll budget is reloaded for each wait. Every wait may use up to POLL_LIMIT reads, whatever the earlier waits used.
- R11: Writes carry a data word with only the targeted bit set (bit 31 = reset, bit 30 = clock gate). Reads have bus_we_o low and address the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin the handshake |
| busy_o | output | 1 | A handshake is in progress |
| done_o | output | 1 | One-cycle pulse: handshake completed |
| err_o | output | 1 | One-cycle pulse: a wait ran out of polls |
| bus_req_o | output | 1 | Access request, held until bus_ready_i |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ready_i on a read |
| bus_ready_i | input | 1 | Access accepted on this edge |

## Verification
Two functions can coincide in one cycle: the end-of-run pulse (done or error) and a fresh start request. Both happen in the cycle where busy_o has just dropped. The bench provokes this by raising start_i in the same cycle in which it sees the pulse. It then expects busy_o high on the next cycle and a complete, correctly ordered second run, with the first run's result unaffected. A start raised in the middle of a run is the other side of this case: it must neither restart the program nor add accesses.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned STEP_W  = 4;
    localparam int unsigned N_STEPS = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_GAP
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_CLR,
        OP_SET,
        OP_WAIT_LO,
        OP_WAIT_HI
    } seq_op_e;

    typedef enum logic {
        TGT_SRST,
        TGT_CGATE
    } seq_tgt_e;

    typedef struct packed {
        seq_op_e  op;
        seq_tgt_e tgt;
    } seq_step_t;

    typedef struct packed {
        seq_state_e         state;
        logic [STEP_W-1:0]  step;
        logic               done;
        logic               err;
    } seq_regs_t;

    // The order of this program is the behaviour of the block.
    function automatic seq_step_t step_lookup(input logic [STEP_W-1:0] idx);
        seq_step_t s;
        case (idx)
            4'd0:    s = '{op: OP_CLR,     tgt: TGT_SRST};
            4'd1:    s = '{op: OP_WAIT_LO, tgt: TGT_SRST};
            4'd2:    s = '{op: OP_CLR,     tgt: TGT_CGATE};
            4'd3:    s = '{op: OP_SET,     tgt: TGT_SRST};
            4'd4:    s = '{op: OP_WAIT_HI, tgt: TGT_CGATE};
            4'd5:    s = '{op: OP_CLR,     tgt: TGT_SRST};
            4'd6:    s = '{op: OP_WAIT_LO, tgt: TGT_SRST};
            4'd7:    s = '{op: OP_CLR,     tgt: TGT_CGATE};
            default: s = '{op: OP_WAIT_LO, tgt: TGT_CGATE};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/psr_step_decode.sv
module psr_step_decode
    import psr_pkg::*;
#(
    parameter int unsigned  ADDR_W    = 32,
    parameter int unsigned  DATA_W    = 32,
    parameter logic [31:0]  BASE_ADDR = 32'h0000_1000,
    parameter int unsigned  SET_OFS   = 4,
    parameter int unsigned  CLR_OFS   = 8,
    parameter int unsigned  SRST_BIT  = 31,
    parameter int unsigned  CGATE_BIT = 30
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              we_o,
    output logic              is_poll_o,
    output logic              want_hi_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              is_last_o
);

    localparam logic [DATA_W-1:0] SRST_MASK  = DATA_W'(1) << SRST_BIT;
    localparam logic [DATA_W-1:0] CGATE_MASK = DATA_W'(1) << CGATE_BIT;
    localparam logic [ADDR_W-1:0] A_BASE     = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_SET      = ADDR_W'(BASE_ADDR + SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR      = ADDR_W'(BASE_ADDR + CLR_OFS);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(N_STEPS - 1);

    seq_step_t cur;

    always_comb begin
        cur       = step_lookup(step_i);
        mask_o    = (cur.tgt == TGT_SRST) ? SRST_MASK : CGATE_MASK;
        is_poll_o = (cur.op == OP_WAIT_LO) || (cur.op == OP_WAIT_HI);
        want_hi_o = (cur.op == OP_WAIT_HI);
        we_o      = !is_poll_o;
        wdata_o   = is_poll_o ? '0 : mask_o;
        case (cur.op)
            OP_CLR:  addr_o = A_CLR;
            OP_SET:  addr_o = A_SET;
            default: addr_o = A_BASE;
        endcase
        is_last_o = (step_i == LAST_STEP);
    end

endmodule

// File: rtl/psr_mask_eval.sv
module psr_mask_eval #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              want_hi_i,
    output logic              pass_o
);

    logic [DATA_W-1:0] bit_ok;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign bit_ok[g] = !mask_i[g] || (rdata_i[g] == want_hi_i);
    end

    assign pass_o = &bit_ok;

endmodule

// File: rtl/psr_tick.sv
module psr_tick #(
    parameter int unsigned DIV = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    if (DIV <= 1) begin : g_every
        assign tick_o = 1'b1;
    end else begin : g_count
        localparam int unsigned CW = $clog2(DIV);
        localparam logic [CW-1:0] TOP = CW'(DIV - 1);

        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            if (clr_i || cnt_q == TOP) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign tick_o = !clr_i && (cnt_q == TOP);
    end

endmodule

// File: rtl/psr_poll_ctr.sv
module psr_poll_ctr #(
    parameter int unsigned LIMIT = 1_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] FULL = CW'(LIMIT);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = FULL;
        end else if (dec_i && cnt_q > ONE) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= FULL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q <= ONE);

endmodule

// File: rtl/periph_reset_sequencer.sv
module periph_reset_sequencer
    import psr_pkg::*;
#(
    parameter int unsigned  ADDR_W     = 32,
    parameter int unsigned  DATA_W     = 32,
    parameter logic [31:0]  BASE_ADDR  = 32'h0000_1000,
    parameter int unsigned  SET_OFS    = 4,
    parameter int unsigned  CLR_OFS    = 8,
    parameter int unsigned  SRST_BIT   = 31,
    parameter int unsigned  CGATE_BIT  = 30,
    parameter int unsigned  CLK_HZ     = 50_000_000,
    parameter int unsigned  POLL_LIMIT = 1_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ready_i
);

    localparam int unsigned TICK_DIV = (CLK_HZ >= 1_000_000) ? (CLK_HZ / 1_000_000) : 1;

    seq_regs_t q, d;

    logic              is_poll, want_hi, is_last, pass, tick, cnt_last;
    logic              cnt_load, cnt_dec, tick_clr;
    logic [DATA_W-1:0] mask;

    psr_step_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR),
        .SET_OFS   (SET_OFS),
        .CLR_OFS   (CLR_OFS),
        .SRST_BIT  (SRST_BIT),
        .CGATE_BIT (CGATE_BIT)
    ) u_dec (
        .step_i    (q.step),
        .addr_o    (bus_addr_o),
        .wdata_o   (bus_wdata_o),
        .we_o      (bus_we_o),
        .is_poll_o (is_poll),
        .want_hi_o (want_hi),
        .mask_o    (mask),
        .is_last_o (is_last)
    );

    psr_mask_eval #(
        .DATA_W (DATA_W)
    ) u_eval (
        .rdata_i   (bus_rdata_i),
        .mask_i    (mask),
        .want_hi_i (want_hi),
        .pass_o    (pass)
    );

    psr_tick #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    psr_poll_ctr #(
        .LIMIT (POLL_LIMIT)
    ) u_polls (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (cnt_load),
        .dec_i  (cnt_dec),
        .last_o (cnt_last)
    );

    assign tick_clr = (q.state != ST_GAP);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state  = ST_BUS;
                    d.step   = '0;
                    cnt_load = 1'b1;
                end
            end
            ST_BUS: begin
                if (bus_ready_i) begin
                    if (!is_poll || pass) begin
                        if (is_last) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.step   = q.step + STEP_W'(1);
                            cnt_load = 1'b1;
                        end
                    end else if (cnt_last) begin
                        d.state = ST_IDLE;
                        d.err   = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                        d.state = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    d.state = ST_BUS;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, step: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.state != ST_IDLE);
    assign bus_req_o = (q.state == ST_BUS);
    assign done_o    = q.done;
    assign err_o     = q.err;

endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
    parameter int unsigned  ADDR_W    = 32,
    parameter int unsigned  DATA_W    = 32,
    parameter logic [31:0]  BASE_ADDR = 32'h0000_1000,
    parameter int unsigned  CLK_HZ    = 50_000_000
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              bus_req_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_we_o,
    input logic              bus_ready_i
);

    localparam int unsigned TICK_DIV = (CLK_HZ >= 1_000_000) ? (CLK_HZ / 1_000_000) : 1;

    int unsigned gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= 0;
        end else if (busy_o && !bus_req_o) begin
            gap_q <= gap_q + 1;
        end else begin
            gap_q <= 0;
        end
    end

    a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !bus_req_o);

    a_r2_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && bus_req_o));

    a_r5_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !bus_req_o) |-> (gap_q < TICK_DIV));

    a_r6_err_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!busy_o && $past(busy_o)));

    a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o);

    a_r7_done_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_ready_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o)));

    a_r11_write_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_we_o) |-> ($countones(bus_wdata_o) == 1));

    a_r11_read_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_we_o) |-> (bus_addr_o == ADDR_W'(BASE_ADDR)));

endmodule

bind periph_reset_sequencer psr_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .CLK_HZ    (CLK_HZ)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o),
    .bus_ready_i (bus_ready_i)
);

// File: tb/sim_periph_reset_sequencer.sv
module sim_periph_reset_sequencer;

    localparam int          LIMIT  = 6;
    localparam int          TICK   = 50;
    localparam logic [31:0] A_BASE = 32'h0000_1000;
    localparam logic [31:0] A_SET  = 32'h0000_1004;
    localparam logic [31:0] A_CLR  = 32'h0000_1008;
    localparam logic [31:0] M_RST  = 32'h8000_0000;
    localparam logic [31:0] M_GATE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, err_o, bus_req_o, bus_we_o;
    logic [31:0] bus_addr_o, bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_ready_i = 1'b0;

    always #10 clk = ~clk;

    periph_reset_sequencer #(.POLL_LIMIT(LIMIT)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_we_o(bus_we_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic        log_we[64];
    logic [31:0] log_addr[64], log_wd[64];
    int          n_log;
    logic        exp_we[64];
    logic [31:0] exp_addr[64], exp_wd[64];
    int          n_exp;
    bit          exp_err;
    int          fails_left[4];
    int          wait_idx;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wait_mask(input int w);
        return (w == 0 || w == 2) ? M_RST : M_GATE;
    endfunction

    function automatic bit wait_hi(input int w);
        return (w == 1);
    endfunction

    task automatic push_exp(input logic we, input logic [31:0] a, input logic [31:0] wd);
        exp_we[n_exp] = we; exp_addr[n_exp] = a; exp_wd[n_exp] = wd; n_exp++;
    endtask

    // Builds the expected access list from the program order (R3) and the per-wait budget (R6, R10).
    task automatic build_exp(input int f0, input int f1, input int f2, input int f3);
        int f[4];
        int w;
        f[0] = f0; f[1] = f1; f[2] = f2; f[3] = f3;
        n_exp = 0; exp_err = 0; w = 0;
        for (int s = 0; s < 9 && !exp_err; s++) begin
            case (s)
                0, 5: push_exp(1'b1, A_CLR, M_RST);
                2, 7: push_exp(1'b1, A_CLR, M_GATE);
                3:    push_exp(1'b1, A_SET, M_RST);
                default: begin
                    int reads;
                    reads = (f[w] >= LIMIT) ? LIMIT : f[w] + 1;
                    for (int r = 0; r < reads; r++) push_exp(1'b0, A_BASE, 32'h0);
                    if (f[w] >= LIMIT) exp_err = 1;
                    w++;
                end
            endcase
        end
    endtask

    // Bus responder and bus-side checks
    bit          prev_hold = 0;
    logic [31:0] hold_addr, hold_wd;
    logic        hold_we;
    int          dly = 0;
    bit          gap_pending = 0;
    int          low_run = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (prev_hold) begin
                check(bus_req_o && bus_addr_o == hold_addr && bus_wdata_o == hold_wd
                      && bus_we_o == hold_we, "R9", "access held while not ready",
                      bus_addr_o, hold_addr);
            end
            prev_hold = 0;
            if (busy_o && bus_req_o) begin
                if (gap_pending) begin
                    check(low_run == TICK, "R5", "poll spacing in cycles", low_run, TICK);
                    gap_pending = 0;
                end
            end else if (busy_o) begin
                low_run++;
            end else begin
                gap_pending = 0;
            end
            if (bus_req_o) begin
                if (dly == 0) begin
                    bus_ready_i = 1'b1;
                    if (n_log < 64) begin
                        log_we[n_log] = bus_we_o; log_addr[n_log] = bus_addr_o;
                        log_wd[n_log] = bus_wdata_o;
                    end
                    n_log++;
                    if (!bus_we_o) begin
                        int w;
                        logic [31:0] r, m;
                        w = (wait_idx > 3) ? 3 : wait_idx;
                        r = $urandom;
                        m = wait_mask(w);
                        if (fails_left[w] > 0) begin
                            bus_rdata_i = wait_hi(w) ? (r & ~m) : (r | m);
                            fails_left[w]--;
                            gap_pending = 1;
                            low_run = 0;
                        end else begin
                            bus_rdata_i = wait_hi(w) ? (r | m) : (r & ~m);
                            wait_idx++;
                        end
                    end else begin
                        bus_rdata_i = $urandom;
                    end
                    dly = $urandom_range(0, 2);
                end else begin
                    dly--;
                    bus_ready_i = 1'b0;
                    prev_hold = 1;
                    hold_addr = bus_addr_o; hold_wd = bus_wdata_o; hold_we = bus_we_o;
                end
            end else begin
                bus_ready_i = 1'b0;
            end
        end
    end

    task automatic run_seq(input int f0, input int f1, input int f2, input int f3,
                           input bit poke_mid, input bit chain_in, input bit chain_out);
        int cyc;
        build_exp(f0, f1, f2, f3);
        fails_left[0] = f0; fails_left[1] = f1; fails_left[2] = f2; fails_left[3] = f3;
        wait_idx = 0;
        n_log = 0;
        if (!chain_in) begin
            @(negedge clk);
            start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && bus_req_o && !done_o && !err_o, "R2",
              "busy and request after start", {30'b0, busy_o, bus_req_o}, 32'h3);
        cyc = 0;
        while (!(done_o || err_o) && cyc < 5000) begin
            if (poke_mid && cyc == 2) start_i = 1'b1;
            if (poke_mid && cyc == 3) start_i = 1'b0;
            @(negedge clk);
            cyc++;
        end
        // R4 decides pass or fail of each poll; R6 and R7 give the outcome.
        check(exp_err ? (err_o && !done_o) : (done_o && !err_o), "R4 R6 R7",
              "outcome err/done", {30'b0, err_o, done_o}, exp_err ? 32'h2 : 32'h1);
        check(!busy_o, "R7", "busy low with end pulse", busy_o, 0);
        check(n_log == n_exp, "R3 R8 R10", "access count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            check(log_we[i] == exp_we[i] && log_addr[i] == exp_addr[i],
                  "R3", "access kind/address", {log_we[i], log_addr[i][30:0]},
                  {exp_we[i], exp_addr[i][30:0]});
            if (exp_we[i])
                check(log_wd[i] == exp_wd[i], "R11", "write data", log_wd[i], exp_wd[i]);
        end
        if (chain_out) begin
            start_i = 1'b1;
        end else begin
            @(negedge clk);
            check(!done_o && !err_o && !busy_o && !bus_req_o, "R6 R7",
                  "pulse lasts one cycle", {29'b0, done_o, err_o, busy_o}, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !err_o && !bus_req_o, "R1", "reset state",
              {28'b0, busy_o, done_o, err_o, bus_req_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !bus_req_o, "R1", "idle after reset release",
              {30'b0, busy_o, bus_req_o}, 0);

        run_seq(0, 0, 0, 0, 0, 0, 0);                 // R3 plain order
        run_seq(1, 2, 3, 4, 0, 0, 0);                 // R5 spacing
        run_seq(LIMIT-1, LIMIT-1, LIMIT-1, LIMIT-1, 0, 0, 0); // R10 reload
        run_seq(LIMIT, 0, 0, 0, 0, 0, 0);             // R6 first wait
        run_seq(0, LIMIT, 0, 0, 0, 0, 0);             // R6 second wait
        run_seq(0, 0, 2, LIMIT, 0, 0, 0);             // R6 last wait
        run_seq(1, 1, 0, 2, 1, 0, 0);                 // R8 start while busy
        run_seq(0, 1, 0, 0, 0, 0, 1);                 // start in done cycle
        run_seq(0, 0, LIMIT, 0, 0, 1, 1);             // start in err cycle
        run_seq(2, 0, 1, 0, 0, 1, 0);

        for (int k = 0; k < 14; k++) begin
            int f[4];
            for (int j = 0; j < 4; j++)
                f[j] = ($urandom_range(0, 7) == 0) ? LIMIT : $urandom_range(0, LIMIT - 1);
            run_seq(f[0], f[1], f[2], f[3], bit'($urandom_range(0, 1)), 0, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule